// File: doc/BRIEF.md
# Complementary PWM Dead-Time and Fault Output Stage

This block sits between a four-channel PWM timer and the pins of a half-bridge driver. Each PWM input is split into a complementary high-side/low-side pair, which gives eight drives in total. Dead time can be inserted per pair. The high-side and low-side turn-on delays are programmed separately in clock ticks. Turn-off is never delayed, so the two switches of one leg are never commanded on together.

A fault path forces every drive to a programmed safe pattern. The fault can come from an external event input, which has its own enable, or from a software event command. In latched mode the fault persists after its source goes away and is released only by an explicit clear command. In non-latched mode it follows its source. Two write-one-to-clear flags record fault entry and fault events, and each flag is gated into a single interrupt request.

Each of the eight pins has its own output enable. A disabled pin is parked low.

Top module: `pwm_guard_stage`

Register writes use `wr_en`, `wr_addr` and `wr_data`. A write takes effect at the clock edge where `wr_en` is high. The register map is:

- CFG (0): [3:0] dead-time enable per pair, [4] latched fault mode, [6:5] fault action, [7] external fault source enable.
- DTLO (1): low-side dead time.
- DTHI (2): high-side dead time.
- OE (3): pin enables.
- IRQEN (4): [0] entry flag, [1] event flag.
- FLAGS (5): write 1 to clear; [0] entry flag, [1] event flag.
- CMD (6): [0] fault clear, [1] software fault event.

## Requirements
- R1: After reset, all eight pin drives and the interrupt are 0.
- R2: Pair i drives pin 2i as high side and pin 2i+1 as low side. With dead time off for that pair, the high side equals the PWM input sampled at the last clock edge, and the low side is its inverse.
- R3: With dead time enabled and DTLO = d, the low side rises only after the input has been sampled low on d+1 consecutive edges, which is d cycles later than without dead time. The low side falls on the first edge that samples the input high.
- R4: With dead time enabled and DTHI = d, the high side rises only after the input has been sampled high on d+1 consecutive edges. The high side falls on the first edge that samples the input low.
- R5: The high side and low side of a pair are never 1 at the same time.
- R6: A dead time of 0 with dead time enabled gives the same undelayed output as dead time disabled.
- R7: A PWM pulse shorter than the relevant dead time produces no pulse on that side.
- R8: While the fault state is active, the fault action selects the drives. Action 01 and action 11 drive all pins low. Action 10 drives the high sides low and the low sides high. Action 00 leaves the drives unchanged. The fault state is entered on the edge that samples a trigger.
- R9: In latched mode (CFG[4]=1) the fault state persists after the trigger is gone until a CMD[0] clear. A clear issued while a trigger is present has no effect.
- R10: In non-latched mode the fault state is active only on the cycle after each edge that sampled a trigger.
- R11: The external fault input triggers only when CFG[7]=1. A CMD[1] software event triggers regardless of CFG[7].
- R12: The entry flag is set when the fault state goes from inactive to active. The event flag is set on every trigger edge. Writing 1 to a flag bit in FLAGS clears it, and a set on the same edge wins over the clear. The interrupt is (IRQEN[0] and entry flag) or (IRQEN[1] and event flag).
- R13: A pin whose OE bit is 0 is driven 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_in | input | 4 | PWM inputs, one per pair |
| fault_in | input | 1 | External fault event (level) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| pin_out | output | 8 | Pin drives, bit 2i high side, bit 2i+1 low side of pair i |
| irq | output | 1 | Fault interrupt request |

## Verification
The main table drives all four PWM inputs at once. Pair 0 has asymmetric dead times of 2 and 3 ticks, and the other pairs pass through. Each row therefore checks the delayed pair against the undelayed pairs. Pair 0 sees long high and low runs, which expose an off-by-one in either delay, and a one-tick pulse, which separates "suppressed" from "shortened". The other pairs get varied bit patterns, which catch a swapped pin or an inverted side. Fault sequences are then run with the trigger held, dropped, and re-asserted around clear commands, and with each action code and mode. These sequences separate latched from following behaviour and show whether a clear is blocked while the trigger is present.

// File: rtl/pwm_guard_pkg.sv
// Package: shared types and register addresses for the PWM guard stage.
// Assumes an 8-bit write bus and a 3-bit register address.
package pwm_guard_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CFG   = 3'd0;
    localparam logic [ADDR_W-1:0] A_DTLO  = 3'd1;
    localparam logic [ADDR_W-1:0] A_DTHI  = 3'd2;
    localparam logic [ADDR_W-1:0] A_OE    = 3'd3;
    localparam logic [ADDR_W-1:0] A_IRQEN = 3'd4;
    localparam logic [ADDR_W-1:0] A_FLAGS = 3'd5;
    localparam logic [ADDR_W-1:0] A_CMD   = 3'd6;

    // Pattern applied to the pins while a fault is active.
    typedef enum logic [1:0] {
        ACT_NONE  = 2'b00,
        ACT_LOW   = 2'b01,
        ACT_BRAKE = 2'b10,
        ACT_LOW_B = 2'b11
    } fault_act_e;

endpackage

// File: rtl/pwm_guard_regs.sv
// Module: register file and command decode for the guard stage.
// Holds the configuration, dead times, pin enables and interrupt enables.
// Command and flag-clear writes come out as single-cycle pulses on the write edge.
// Assumes the CFG field layout stated in the brief.
module pwm_guard_regs
    import pwm_guard_pkg::*;
#(
    parameter int NUM_PAIRS = 4,
    parameter int DATA_W    = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    output logic [NUM_PAIRS-1:0]   dt_en,
    output logic                   latch_mode,
    output fault_act_e             fault_act,
    output logic                   src_en,
    output logic [DATA_W-1:0]      dt_lo,
    output logic [DATA_W-1:0]      dt_hi,
    output logic [2*NUM_PAIRS-1:0] pin_oe,
    output logic [1:0]             irq_en,
    output logic [1:0]             flag_clr,
    output logic                   clr_cmd,
    output logic                   sw_evt
);

    localparam int NPINS = 2 * NUM_PAIRS;

    logic [DATA_W-1:0] cfg_q;

    // Configuration storage, written on addressed strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            dt_lo  <= '0;
            dt_hi  <= '0;
            pin_oe <= '0;
            irq_en <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CFG:   cfg_q  <= wr_data;
                A_DTLO:  dt_lo  <= wr_data;
                A_DTHI:  dt_hi  <= wr_data;
                A_OE:    pin_oe <= wr_data[NPINS-1:0];
                A_IRQEN: irq_en <= wr_data[1:0];
                default: ;
            endcase
        end
    end

    // Field split of the configuration register.
    always_comb begin
        dt_en      = cfg_q[NUM_PAIRS-1:0];
        latch_mode = cfg_q[4];
        fault_act  = fault_act_e'(cfg_q[6:5]);
        src_en     = cfg_q[7];
    end

    // Single-cycle command and clear pulses.
    always_comb begin
        flag_clr = (wr_en && wr_addr == A_FLAGS) ? wr_data[1:0] : 2'b00;
        clr_cmd  = wr_en && (wr_addr == A_CMD) && wr_data[0];
        sw_evt   = wr_en && (wr_addr == A_CMD) && wr_data[1];
    end

    p_pulse_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_cmd || sw_evt) |-> (wr_en && wr_addr == A_CMD));

endmodule

// File: rtl/pwm_guard_deadtime.sv
// Module: dead-time generator for one complementary pair.
// It registers the PWM input and counts how many consecutive edges have held
// the current level, saturating at the top of the count.
// A side turns on only once the run length reaches its dead time.
// Turn-off happens on the first edge of the opposite level.
// When dead time is disabled the threshold is 0, which gives a plain pass-through.
module pwm_guard_deadtime #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_in,
    input  logic             dt_en,
    input  logic [CNT_W-1:0] dt_lo,
    input  logic [CNT_W-1:0] dt_hi,
    output logic             hs_o,
    output logic             ls_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             lvl_q;
    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] thr_hi;
    logic [CNT_W-1:0] thr_lo;

    // Sample the input and track the length of its current run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
            run_q <= '0;
        end else begin
            lvl_q <= pwm_in;
            if (pwm_in != lvl_q)
                run_q <= '0;
            else if (run_q != CNT_MAX)
                run_q <= run_q + 1'b1;
        end
    end

    // Select the effective turn-on thresholds.
    always_comb begin
        thr_hi = dt_en ? dt_hi : '0;
        thr_lo = dt_en ? dt_lo : '0;
    end

    // Gate each side on its level and its elapsed run length.
    always_comb begin
        hs_o = lvl_q  && (run_q >= thr_hi);
        ls_o = !lvl_q && (run_q >= thr_lo);
    end

    p_pair_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_o && ls_o));
    p_hs_fall_now_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_in |=> !hs_o);
    p_ls_fall_now_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_in |=> !ls_o);

endmodule

// File: rtl/pwm_guard_fault.sv
// Module: fault state machine, event flags and interrupt request.
// A trigger is the enabled external event or a software event.
// In latched mode the state holds until a clear arrives with no trigger present.
// In non-latched mode the state follows the trigger with one register of delay.
module pwm_guard_fault (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fault_in,
    input  logic       src_en,
    input  logic       sw_evt,
    input  logic       latch_mode,
    input  logic       clr_cmd,
    input  logic [1:0] flag_clr,
    input  logic [1:0] irq_en,
    output logic       fault_q,
    output logic       irq
);

    logic trig;
    logic entry_flag;
    logic event_flag;

    // Combine the fault sources.
    always_comb begin
        trig = (fault_in && src_en) || sw_evt;
    end

    // Fault state: a trigger wins, latched mode holds until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fault_q <= 1'b0;
        else
            fault_q <= trig || (latch_mode && fault_q && !clr_cmd);
    end

    // Sticky flags, write-one-to-clear, with set winning over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_flag <= 1'b0;
            event_flag <= 1'b0;
        end else begin
            if (trig && !fault_q)
                entry_flag <= 1'b1;
            else if (flag_clr[0])
                entry_flag <= 1'b0;
            if (trig)
                event_flag <= 1'b1;
            else if (flag_clr[1])
                event_flag <= 1'b0;
        end
    end

    // Interrupt request from the gated flags.
    always_comb begin
        irq = (irq_en[0] && entry_flag) || (irq_en[1] && event_flag);
    end

    p_clear_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_cmd && trig) |=> fault_q);
    p_latch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_mode && fault_q && !clr_cmd) |=> fault_q);
    p_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_mode && !trig) |=> !fault_q);
    p_event_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> event_flag);
    p_masked_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_en && !sw_evt && !fault_q) |=> !fault_q);

endmodule

// File: rtl/pwm_guard_stage.sv
// Module: top of the complementary PWM output stage.
// It splits four PWM inputs into eight drives through per-pair dead-time
// generators and applies the fault pattern and the pin enables.
// Pin 2i is the high side and pin 2i+1 the low side of pair i.
module pwm_guard_stage
    import pwm_guard_pkg::*;
#(
    parameter int NUM_PAIRS = 4,
    parameter int DATA_W    = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_PAIRS-1:0]   pwm_in,
    input  logic                   fault_in,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    output logic [2*NUM_PAIRS-1:0] pin_out,
    output logic                   irq
);

    localparam int NPINS = 2 * NUM_PAIRS;

    logic [NUM_PAIRS-1:0] dt_en;
    logic                 latch_mode;
    fault_act_e           fault_act;
    logic                 src_en;
    logic [DATA_W-1:0]    dt_lo;
    logic [DATA_W-1:0]    dt_hi;
    logic [NPINS-1:0]     pin_oe;
    logic [1:0]           irq_en;
    logic [1:0]           flag_clr;
    logic                 clr_cmd;
    logic                 sw_evt;
    logic                 fault_q;
    logic [NUM_PAIRS-1:0] hs;
    logic [NUM_PAIRS-1:0] ls;

    pwm_guard_regs #(
        .NUM_PAIRS (NUM_PAIRS),
        .DATA_W    (DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .dt_en      (dt_en),
        .latch_mode (latch_mode),
        .fault_act  (fault_act),
        .src_en     (src_en),
        .dt_lo      (dt_lo),
        .dt_hi      (dt_hi),
        .pin_oe     (pin_oe),
        .irq_en     (irq_en),
        .flag_clr   (flag_clr),
        .clr_cmd    (clr_cmd),
        .sw_evt     (sw_evt)
    );

    pwm_guard_fault u_fault (
        .clk        (clk),
        .rst_n      (rst_n),
        .fault_in   (fault_in),
        .src_en     (src_en),
        .sw_evt     (sw_evt),
        .latch_mode (latch_mode),
        .clr_cmd    (clr_cmd),
        .flag_clr   (flag_clr),
        .irq_en     (irq_en),
        .fault_q    (fault_q),
        .irq        (irq)
    );

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        logic hs_f;
        logic ls_f;

        pwm_guard_deadtime #(
            .CNT_W (DATA_W)
        ) u_dt (
            .clk    (clk),
            .rst_n  (rst_n),
            .pwm_in (pwm_in[g]),
            .dt_en  (dt_en[g]),
            .dt_lo  (dt_lo),
            .dt_hi  (dt_hi),
            .hs_o   (hs[g]),
            .ls_o   (ls[g])
        );

        // Substitute the fault pattern for this pair while a fault is active.
        always_comb begin
            hs_f = hs[g];
            ls_f = ls[g];
            if (fault_q) begin
                case (fault_act)
                    ACT_NONE:  ;
                    ACT_BRAKE: begin hs_f = 1'b0; ls_f = 1'b1; end
                    default:   begin hs_f = 1'b0; ls_f = 1'b0; end
                endcase
            end
        end

        // Apply the per-pin enables.
        always_comb begin
            pin_out[2*g]   = hs_f && pin_oe[2*g];
            pin_out[2*g+1] = ls_f && pin_oe[2*g+1];
        end
    end

    p_oe_mask_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0);
    p_fault_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q && (fault_act == ACT_LOW || fault_act == ACT_LOW_B)) |-> (pin_out == '0));

endmodule

// File: tb/tb_pwm_guard_stage.sv
// Bench: a stimulus table for the dead-time path, then directed fault, enable and reset tests.
module tb_pwm_guard_stage;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pwm_in = 4'h0;
    logic       fault_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] pin_out;
    logic       irq;

    int checks = 0;
    int errors = 0;
    int overlaps = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwm_guard_stage dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwm_in   (pwm_in),
        .fault_in (fault_in),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .pin_out  (pin_out),
        .irq      (irq)
    );

    // Table rows are {pwm nibble, expected pins}. Pair 0 has DTLO=2 and DTHI=3, and the other pairs pass through.
    localparam int NROWS = 11;
    localparam logic [11:0] TABLE [NROWS] = '{
        {4'b0001, 8'hA8}, {4'b1011, 8'h64}, {4'b1111, 8'h54}, {4'b0101, 8'h99},
        {4'b0010, 8'hA4}, {4'b1000, 8'h68}, {4'b1100, 8'h5A}, {4'b0111, 8'h94},
        {4'b0000, 8'hA8}, {4'b1110, 8'h54}, {4'b1010, 8'h66}
    };

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Monitor for R5: the two sides of a pair must never both be high.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < 4; i++)
                if (pin_out[2*i] && pin_out[2*i+1]) overlaps++;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        chk("R1 pins after reset", pin_out, 8'h00);
        chk("R1 irq after reset", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;
        tick();
        chk("R1 pins idle, outputs disabled", pin_out, 8'h00);

        // Table walk: R2, R3, R4 and R7.
        wr(3'd3, 8'hFF);
        wr(3'd1, 8'd2);
        wr(3'd2, 8'd3);
        wr(3'd0, 8'h01);
        repeat (4) tick();
        chk("R3 low side on after long low run", pin_out, 8'hAA);
        for (int r = 0; r < NROWS; r++) begin
            pwm_in = TABLE[r][11:8];
            tick();
            chk($sformatf("R2 R3 R4 R7 table row %0d", r), pin_out, TABLE[r][7:0]);
        end

        // R6: dead time enabled with zero values.
        wr(3'd1, 8'd0);
        wr(3'd2, 8'd0);
        wr(3'd0, 8'h0F);
        pwm_in = 4'b0110; tick();
        chk("R6 zero dead time pass-through", pin_out, 8'h96);
        pwm_in = 4'b1001; tick();
        chk("R6 zero dead time toggled", pin_out, 8'h69);

        // R13: pin enables.
        wr(3'd0, 8'h00);
        pwm_in = 4'h0;
        wr(3'd3, 8'h0F);
        chk("R13 masked pins low", pin_out, 8'h0A);
        wr(3'd3, 8'hFF);

        // R8, R9, R12: latched mode with the all-low action.
        pwm_in = 4'hF;
        wr(3'd4, 8'h01);
        wr(3'd0, 8'hB0);
        chk("R8 no fault baseline", pin_out, 8'h55);
        chk("R12 irq idle", {7'd0, irq}, 8'h00);
        fault_in = 1'b1; tick();
        chk("R8 fault drives all low", pin_out, 8'h00);
        chk("R12 irq on fault entry", {7'd0, irq}, 8'h01);
        wr(3'd6, 8'h01);
        chk("R9 clear blocked while fault present", pin_out, 8'h00);
        fault_in = 1'b0; tick(); tick();
        chk("R9 latched after source gone", pin_out, 8'h00);
        wr(3'd6, 8'h01);
        chk("R9 clear releases fault", pin_out, 8'h55);
        chk("R12 entry flag still set", {7'd0, irq}, 8'h01);
        wr(3'd5, 8'h01);
        chk("R12 entry flag cleared", {7'd0, irq}, 8'h00);
        wr(3'd4, 8'h02);
        chk("R12 event flag gated in", {7'd0, irq}, 8'h01);
        wr(3'd5, 8'h02);
        chk("R12 event flag cleared", {7'd0, irq}, 8'h00);

        // R8: brake action and no action.
        wr(3'd0, 8'hD0);
        fault_in = 1'b1; tick();
        chk("R8 brake pattern", pin_out, 8'hAA);
        fault_in = 1'b0;
        wr(3'd6, 8'h01);
        chk("R8 brake released", pin_out, 8'h55);
        wr(3'd0, 8'h90);
        fault_in = 1'b1; tick();
        chk("R8 action none leaves pins", pin_out, 8'h55);
        fault_in = 1'b0;
        wr(3'd6, 8'h01);

        // R10: non-latched mode.
        wr(3'd0, 8'hA0);
        fault_in = 1'b1; tick();
        chk("R10 follow mode fault active", pin_out, 8'h00);
        fault_in = 1'b0; tick();
        chk("R10 follow mode releases", pin_out, 8'h55);

        // R11: source enable and software event.
        wr(3'd0, 8'h30);
        fault_in = 1'b1; tick(); tick();
        chk("R11 disabled source ignored", pin_out, 8'h55);
        wr(3'd6, 8'h02);
        chk("R11 software event faults", pin_out, 8'h00);
        fault_in = 1'b0;
        wr(3'd6, 8'h01);
        chk("R11 software fault cleared", pin_out, 8'h55);

        checks++;
        if (overlaps != 0) begin
            errors++;
            $display("FAIL R5 overlap count: got %0d expected 0", overlaps);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule